// File: doc/BRIEF.md
# Second-Group Operate Microinstruction Unit

This unit executes the second family of operate instructions of a 12-bit accumulator machine. It takes one instruction word together with the current accumulator, link, front-panel switch value and the already-advanced program counter. From these it produces the next program counter, the next accumulator and a stop request. It builds a combined skip condition from three tests: accumulator negative, accumulator zero and link set. A reverse bit can turn this condition into its complement. When the skip holds, the program counter moves past one more word.

The accumulator side runs in a fixed order. The skip tests look at the incoming accumulator. An optional clear comes next, and an optional OR of the switch value follows the clear, so clear together with switch-OR loads the switches. All outputs are registered and appear one clock after the inputs are presented. A word that carries the family's opcode but has its least significant bit set is flagged as unsupported, and it leaves the accumulator and program counter untouched. Every other word passes the accumulator and program counter straight through, with no valid flag.

Top module: `g2_operate_unit`

## Requirements
- R1: `valid` is 1 in the cycle after an instruction with instr[11:9]=3'b111, instr[8]=1 and instr[0]=0 was presented, and 0 otherwise.
- R2: The skip condition is the OR of the enabled tests: instr[6] tests ac_in[11]=1, instr[5] tests ac_in=0, and instr[4] tests l_in=1. `skip` is registered with the other outputs.
- R3: With instr[3]=1 the skip is the complement of that OR. So with no test enabled, reverse mode always skips and normal mode never skips.
- R4: In a valid cycle, pc_out equals pc_in+1 modulo 4096 when skip is 1, and pc_in otherwise.
- R5: instr[7] clears the accumulator, and the skip tests still see the pre-clear ac_in.
- R6: instr[2] ORs sr into the accumulator after any clear. Clear plus switch-OR yields exactly sr.
- R7: `halt` is 1 in the cycle after a valid instruction with instr[1]=1, and 0 otherwise.
- R8: When instr[11:8]=4'b1111 and instr[0]=1, `unsupported` is 1 and `valid`, `skip` and `halt` are 0. ac_out equals ac_in and pc_out equals pc_in.
- R9: For any other opcode, `valid`, `unsupported`, `skip` and `halt` are 0, ac_out equals ac_in and pc_out equals pc_in.
- R10: While rst_n is low, every output is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator |
| l_in | input | 1 | Current link bit |
| sr | input | 12 | Front-panel switch value |
| pc_in | input | 12 | Program counter, already advanced past the instruction |
| pc_out | output | 12 | Next program counter |
| ac_out | output | 12 | Next accumulator |
| skip | output | 1 | Skip taken |
| halt | output | 1 | Stop request |
| valid | output | 1 | A supported instruction was executed |
| unsupported | output | 1 | Reserved encoding seen; state left unchanged |

## Verification
The hardest case to reach is a skip in reverse mode with all three tests enabled. It needs the accumulator non-negative and nonzero with the link clear at the same time, while any single one of those conditions kills it. Random stimulus seldom hits that combination. Directed words therefore drive it with the accumulator at 1 and the link at 0, then move one condition at a time to show the skip disappear. The same is done with clear combined with a zero test on a nonzero accumulator, and with a skip at program counter 4095, which shows the pre-clear evaluation and the wrap to 0.

// File: rtl/g2_pkg.sv
package g2_pkg;
   localparam int INSTR_W = 12;

   // instruction bit positions (bit 11 is the most significant)
   localparam int B_CLEAR = 7;
   localparam int B_NEG   = 6;
   localparam int B_ZERO  = 5;
   localparam int B_LINK  = 4;
   localparam int B_INV   = 3;
   localparam int B_OSR   = 2;
   localparam int B_HALT  = 1;
   localparam int B_RSVD  = 0;

   typedef enum logic [1:0] {
      G2_OTHER = 2'd0,
      G2_EXEC  = 2'd1,
      G2_RSVD  = 2'd2
   } g2_class_e;

   typedef struct packed {
      logic clear_ac;
      logic on_neg;
      logic on_zero;
      logic on_link;
      logic invert;
      logic or_switch;
      logic stop;
   } g2_ctl_t;
endpackage

// File: rtl/g2_decode.sv
module g2_decode
   import g2_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output g2_class_e          cls,
   output g2_ctl_t            ctl
);
   logic family_hit;

   assign family_hit = (instr[11:9] == 3'b111) && instr[8];

   always_comb begin
      ctl.clear_ac  = instr[B_CLEAR];
      ctl.on_neg    = instr[B_NEG];
      ctl.on_zero   = instr[B_ZERO];
      ctl.on_link   = instr[B_LINK];
      ctl.invert    = instr[B_INV];
      ctl.or_switch = instr[B_OSR];
      ctl.stop      = instr[B_HALT];
      if (!family_hit)
         cls = G2_OTHER;
      else if (instr[B_RSVD])
         cls = G2_RSVD;
      else
         cls = G2_EXEC;
   end
endmodule

// File: rtl/g2_skip_eval.sv
module g2_skip_eval #(
   parameter int W          = 12,
   parameter bit ZERO_CHAIN = 1'b0
) (
   input  logic         on_neg,
   input  logic         on_zero,
   input  logic         on_link,
   input  logic         invert,
   input  logic [W-1:0] ac,
   input  logic         link,
   output logic         take_skip
);
   logic ac_is_zero;
   logic any_hit;

   generate
      if (ZERO_CHAIN) begin : g_zero_chain
         logic [W:0] seen_one;
         assign seen_one[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign seen_one[i+1] = seen_one[i] | ac[i];
         end
         assign ac_is_zero = ~seen_one[W];
      end else begin : g_zero_reduce
         assign ac_is_zero = ~(|ac);
      end
   endgenerate

   assign any_hit   = (on_neg & ac[W-1]) | (on_zero & ac_is_zero) | (on_link & link);
   assign take_skip = any_hit ^ invert;
endmodule

// File: rtl/g2_acc_path.sv
module g2_acc_path #(
   parameter int W    = 12,
   parameter int SR_W = 12
) (
   input  logic            clear_ac,
   input  logic            or_switch,
   input  logic [W-1:0]    ac,
   input  logic [SR_W-1:0] sr,
   output logic [W-1:0]    ac_next
);
   logic [W-1:0] sr_ext;
   logic [W-1:0] after_clear;

   generate
      if (SR_W == W) begin : g_sr_full
         assign sr_ext = sr;
      end else begin : g_sr_narrow
         assign sr_ext = {{(W-SR_W){1'b0}}, sr};
      end
   endgenerate

   assign after_clear = clear_ac ? '0 : ac;
   assign ac_next     = or_switch ? (after_clear | sr_ext) : after_clear;
endmodule

// File: rtl/g2_operate_unit.sv
module g2_operate_unit
   import g2_pkg::*;
#(
   parameter int W          = 12,
   parameter int SR_W       = 12,
   parameter int PC_W       = 12,
   parameter bit ZERO_CHAIN = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [W-1:0]        ac_in,
   input  logic                l_in,
   input  logic [SR_W-1:0]     sr,
   input  logic [PC_W-1:0]     pc_in,
   output logic [PC_W-1:0]     pc_out,
   output logic [W-1:0]        ac_out,
   output logic                skip,
   output logic                halt,
   output logic                valid,
   output logic                unsupported
);
   generate
      if (W < 2) begin : g_bad_w
         $error("g2_operate_unit: W must be at least 2");
      end
      if (SR_W < 1 || SR_W > W) begin : g_bad_sr
         $error("g2_operate_unit: SR_W must lie in 1..W");
      end
      if (PC_W < 1) begin : g_bad_pc
         $error("g2_operate_unit: PC_W must be positive");
      end
   endgenerate

   g2_class_e          cls;
   g2_ctl_t            ctl;
   logic               skip_c;
   logic [W-1:0]       ac_calc;
   logic [PC_W-1:0]    pc_n;
   logic [W-1:0]       ac_n;
   logic               skip_n, halt_n, valid_n, rsvd_n;

   g2_decode u_dec (
      .instr (instr),
      .cls   (cls),
      .ctl   (ctl)
   );

   g2_skip_eval #(.W(W), .ZERO_CHAIN(ZERO_CHAIN)) u_skip (
      .on_neg    (ctl.on_neg),
      .on_zero   (ctl.on_zero),
      .on_link   (ctl.on_link),
      .invert    (ctl.invert),
      .ac        (ac_in),
      .link      (l_in),
      .take_skip (skip_c)
   );

   g2_acc_path #(.W(W), .SR_W(SR_W)) u_acc (
      .clear_ac  (ctl.clear_ac),
      .or_switch (ctl.or_switch),
      .ac        (ac_in),
      .sr        (sr),
      .ac_next   (ac_calc)
   );

   always_comb begin
      pc_n    = pc_in;
      ac_n    = ac_in;
      skip_n  = 1'b0;
      halt_n  = 1'b0;
      valid_n = 1'b0;
      rsvd_n  = 1'b0;
      unique case (cls)
         G2_EXEC: begin
            skip_n  = skip_c;
            pc_n    = pc_in + PC_W'(skip_c);
            ac_n    = ac_calc;
            halt_n  = ctl.stop;
            valid_n = 1'b1;
         end
         G2_RSVD: rsvd_n = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_out      <= '0;
         ac_out      <= '0;
         skip        <= 1'b0;
         halt        <= 1'b0;
         valid       <= 1'b0;
         unsupported <= 1'b0;
      end else begin
         pc_out      <= pc_n;
         ac_out      <= ac_n;
         skip        <= skip_n;
         halt        <= halt_n;
         valid       <= valid_n;
         unsupported <= rsvd_n;
      end
   end
endmodule

// File: rtl/g2_operate_unit_chk.sv
module g2_operate_unit_chk #(
   parameter int W    = 12,
   parameter int PC_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic [11:0]     instr,
   input logic [W-1:0]    ac_in,
   input logic [PC_W-1:0] pc_in,
   input logic [PC_W-1:0] pc_out,
   input logic [W-1:0]    ac_out,
   input logic            skip,
   input logic            halt,
   input logic            valid,
   input logic            unsupported
);
   assert_one_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({valid, unsupported}));

   assert_skip_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> valid);

   assert_pc_bump_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && skip) |-> (pc_out == PC_W'($past(pc_in) + PC_W'(1))));

   assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !skip) |-> (pc_out == $past(pc_in)));

   assert_ac_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !$past(instr[7]) && !$past(instr[2])) |-> (ac_out == $past(ac_in)));

   assert_halt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (valid && $past(instr[1])));

   assert_rsvd_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> (ac_out == $past(ac_in) && pc_out == $past(pc_in) && !halt && !skip));
endmodule

bind g2_operate_unit g2_operate_unit_chk #(.W(W), .PC_W(PC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr       (instr),
   .ac_in       (ac_in),
   .pc_in       (pc_in),
   .pc_out      (pc_out),
   .ac_out      (ac_out),
   .skip        (skip),
   .halt        (halt),
   .valid       (valid),
   .unsupported (unsupported)
);

// File: tb/g2_operate_unit_tb.sv
`timescale 1ns/1ps
module g2_operate_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] instr, ac_in, sr, pc_in;
   logic        l_in;
   logic [11:0] pc_out, ac_out;
   logic        skip, halt, valid, unsupported;

   always #4 clk = ~clk;

   g2_operate_unit u_dut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .ac_in(ac_in), .l_in(l_in),
      .sr(sr), .pc_in(pc_in), .pc_out(pc_out), .ac_out(ac_out), .skip(skip),
      .halt(halt), .valid(valid), .unsupported(unsupported)
   );

   int    checks = 0;
   int    failures = 0;
   bit    have_exp = 0;
   string exp_tag;
   int    e_pc, e_ac, e_skip, e_halt, e_valid, e_uns;

   task automatic chk(string tag, string field, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0o expected=%0o", tag, field, act, exp);
      end
   endtask

   task automatic compare();
      chk(exp_tag, "valid", int'(valid), e_valid);
      chk(exp_tag, "unsupported", int'(unsupported), e_uns);
      chk(exp_tag, "skip", int'(skip), e_skip);
      chk(exp_tag, "pc_out", int'(pc_out), e_pc);
      chk(exp_tag, "ac_out", int'(ac_out), e_ac);
      chk(exp_tag, "halt", int'(halt), e_halt);
   endtask

   // behavioural reference of the requirements
   task automatic model(int i, int a, int l, int s, int p);
      int cond;
      e_pc = p; e_ac = a; e_skip = 0; e_halt = 0; e_valid = 0; e_uns = 0;
      if ((i / 256) != 15) return;                 // R9
      if (i % 2 == 1) begin e_uns = 1; return; end  // R8
      e_valid = 1;
      cond = 0;
      if (((i / 64) % 2 == 1) && a >= 2048) cond = 1;
      if (((i / 32) % 2 == 1) && a == 0)    cond = 1;
      if (((i / 16) % 2 == 1) && l == 1)    cond = 1;
      e_skip = ((i / 8) % 2 == 1) ? 1 - cond : cond;
      e_pc = (p + e_skip) % 4096;
      e_ac = ((i / 128) % 2 == 1) ? 0 : a;
      if ((i / 4) % 2 == 1) e_ac = e_ac | s;
      e_halt = (i / 2) % 2;
   endtask

   task automatic step(string tag, logic [11:0] i, logic [11:0] a, logic l,
                       logic [11:0] s, logic [11:0] p);
      @(negedge clk);
      if (have_exp) compare();
      instr = i; ac_in = a; l_in = l; sr = s; pc_in = p;
      model(int'(i), int'(a), int'(l), int'(s), int'(p));
      exp_tag = tag;
      have_exp = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      instr = 12'o7777; ac_in = 12'o7777; l_in = 1'b1; sr = 12'o7777; pc_in = 12'o7777;
      repeat (3) @(posedge clk);
      @(negedge clk);
      e_pc = 0; e_ac = 0; e_skip = 0; e_halt = 0; e_valid = 0; e_uns = 0;
      exp_tag = "R10 reset";
      compare();
      rst_n = 1'b1;

      // R3: no tests, normal and reverse
      step("R3 none-normal",  12'o7400, 12'o0123, 1'b1, 12'o0000, 12'o0100);
      step("R3 none-reverse", 12'o7410, 12'o0123, 1'b0, 12'o0000, 12'o0100);
      // R2: individual tests
      step("R2 neg-hit",   12'o7500, 12'o4000, 1'b0, 12'o0000, 12'o0200);
      step("R2 neg-miss",  12'o7500, 12'o3777, 1'b0, 12'o0000, 12'o0200);
      step("R2 zero-hit",  12'o7440, 12'o0000, 1'b0, 12'o0000, 12'o0300);
      step("R2 zero-miss", 12'o7440, 12'o0001, 1'b1, 12'o0000, 12'o0300);
      step("R2 link-hit",  12'o7420, 12'o0005, 1'b1, 12'o0000, 12'o0400);
      step("R2 or-combo",  12'o7560, 12'o0000, 1'b0, 12'o0000, 12'o0400);
      // R3: reverse with all tests
      step("R3 rev-all-skip",  12'o7570, 12'o0001, 1'b0, 12'o0000, 12'o0500);
      step("R3 rev-all-link",  12'o7570, 12'o0001, 1'b1, 12'o0000, 12'o0500);
      step("R3 rev-all-zero",  12'o7570, 12'o0000, 1'b0, 12'o0000, 12'o0500);
      step("R3 rev-all-neg",   12'o7570, 12'o4001, 1'b0, 12'o0000, 12'o0500);
      // R5: clear after test
      step("R5 cla-sza-old",   12'o7640, 12'o0005, 1'b0, 12'o0000, 12'o0600);
      step("R5 cla-sma-old",   12'o7700, 12'o4400, 1'b0, 12'o0000, 12'o0600);
      // R6: switch OR
      step("R6 osr-or",        12'o7404, 12'o0701, 1'b0, 12'o5010, 12'o0700);
      step("R6 cla-osr-load",  12'o7604, 12'o7070, 1'b0, 12'o1234, 12'o0700);
      // R7: halt
      step("R7 halt",          12'o7402, 12'o0042, 1'b0, 12'o0000, 12'o1000);
      step("R7 halt-combo",    12'o7646, 12'o0000, 1'b1, 12'o0017, 12'o1000);
      // R4: wrap
      step("R4 pc-wrap",       12'o7410, 12'o0000, 1'b0, 12'o0000, 12'o7777);
      step("R4 pc-nowrap",     12'o7400, 12'o0000, 1'b0, 12'o0000, 12'o7777);
      // R8: reserved bit
      step("R8 rsvd",          12'o7401, 12'o1357, 1'b1, 12'o7777, 12'o2000);
      step("R8 rsvd-all",      12'o7777, 12'o0000, 1'b1, 12'o7777, 12'o7777);
      // R9 / R1: other opcodes
      step("R9 group1",        12'o7200, 12'o2222, 1'b0, 12'o7777, 12'o3000);
      step("R9 iot",           12'o6046, 12'o0101, 1'b1, 12'o7777, 12'o3001);
      step("R1 memref",        12'o1440, 12'o0000, 1'b0, 12'o7777, 12'o3002);

      // mixed stimulus, mostly in the family
      for (int n = 0; n < 600; n++) begin
         logic [11:0] ri, ra, rs, rp;
         logic        rl;
         ri = (n % 6 == 0) ? 12'($urandom()) : {4'hF, 8'($urandom())};
         case (n % 4)
            0: ra = 12'o0000;
            1: ra = 12'o4000 | 12'($urandom_range(0, 15));
            2: ra = 12'o0001;
            default: ra = 12'($urandom());
         endcase
         rl = 1'($urandom());
         rs = 12'($urandom());
         rp = (n % 9 == 0) ? 12'o7777 : 12'($urandom());
         step("R1-R9 mixed", ri, ra, rl, rs, rp);
      end

      @(negedge clk);
      compare();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule